// File: doc/BRIEF.md
# Interrupt Class Priority Arbiter

This block keeps track of which asynchronous interrupt sources of a processor core are waiting, and decides which interrupt class the core services when it asks. The core raises a service request. On the rising edge of that request the arbiter picks one class and presents it for a single cycle, together with a 16-bit external interruption code. In the same cycle it updates its own pending state. A hard-interrupt line tells the core whether anything is still waiting.

Three sources are held in queues: queued external entries, each with its own code; machine-check entries, each with a type; and I/O requests. The external and machine-check queues are last-in-first-out. Two timer events, the clock comparator and the CPU timer, are single pending flags. Each class is gated by its own status-word mask bit. A synchronous exception that is already pending overrides every asynchronous class. Machine checks and I/O each also need a control-register enable bit. If that bit is clear, the class stays pending and nothing is delivered. Pushing into a full queue, or servicing a machine check of an unknown type, sets a sticky fatal flag.

Top module: `irq_class_arbiter`

## Requirements
- R1: When `exc_pending` is high at a service request, the class is EXC (code 1). No pending state changes.
- R2: Without an exception, the eligible classes are tried in a fixed order: machine check (2), then external (3), then I/O (4). At most one class is delivered per request.
- R3: A class is eligible only while its mask input (`psw_mck_en`, `psw_ext_en`, `psw_io_en`) is high. A masked class stays pending and lower classes are tried.
- R4: Inside the external class, a queued entry comes first and its own code is presented. If there is none, a pending clock-comparator event presents code 0x1004. Otherwise a pending CPU-timer event presents code 0x1005. Every other class presents code 0.
- R5: Injecting a timer code clears the clock-comparator flag. The CPU-timer flag is not cleared, so the CPU timer is delivered again on every later request until reset.
- R6: A machine check is delivered only if its type is 1 and `cr_mck_en` is high. With `cr_mck_en` low, the result is NONE (0), the entry stays pending and no lower class is taken. A type other than 1 gives NONE and sets `fatal`.
- R7: The external and machine-check queues serve their most recent entry first. A class stops being pending once its queue is empty.
- R8: `hard_irq` is high exactly while any queue is non-empty or a timer flag is set. It falls in the cycle after the last pending item is consumed.
- R9: A push into a full queue is dropped and sets `fatal`. `fatal` stays set until reset.
- R10: `sel_valid` is high for one cycle, one clock after the request's rising edge. A request held high produces no further selections. While `sel_valid` is low, `sel_class` and `ext_code` are zero.
- R11: An I/O request is delivered only while `io_cr_en` is high. Otherwise the result is NONE and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_push | input | 1 | Queue an external entry |
| ext_push_code | input | 16 | Code of the queued external entry |
| mck_push | input | 1 | Queue a machine-check entry |
| mck_push_type | input | 8 | Type of the machine-check entry |
| io_push | input | 1 | Queue an I/O request |
| ckc_set | input | 1 | Clock-comparator event pulse |
| cpt_set | input | 1 | CPU-timer event pulse |
| psw_mck_en | input | 1 | Machine-check mask bit |
| psw_ext_en | input | 1 | External mask bit |
| psw_io_en | input | 1 | I/O mask bit |
| cr_mck_en | input | 1 | Control-register enable for machine checks |
| io_cr_en | input | 1 | Control-register enable for I/O |
| exc_pending | input | 1 | A synchronous exception is already pending |
| svc_req | input | 1 | Service request; acts on its rising edge |
| sel_valid | output | 1 | One-cycle strobe for a selection |
| sel_class | output | 3 | 0 NONE, 1 EXC, 2 MCK, 3 EXT, 4 IO |
| ext_code | output | 16 | Injected or queued external code |
| hard_irq | output | 1 | Something is pending |
| fatal | output | 1 | Sticky fatal condition |

## Verification
The hardest situation to reach is the one where the flag that was not cleared decides the next outcome. After a clock-comparator injection, the CPU timer is still waiting and must be delivered, repeatedly, on later requests. A machine check blocked by its control bit must hide a pending external entry without consuming it. The stimulus gets there by loading several sources before a single request, then issuing a chain of requests whose expected class and code are queued in the scoreboard in order. The control bit is toggled between requests. `hard_irq` is sampled after each request to observe what is still pending.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int CODE_W = 16;
  localparam int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE = 3'd0,
    CLS_EXC  = 3'd1,
    CLS_MCK  = 3'd2,
    CLS_EXT  = 3'd3,
    CLS_IO   = 3'd4
  } irq_cls_e;

  localparam logic [CODE_W-1:0] CODE_CLK_CMP = 16'h1004;
  localparam logic [CODE_W-1:0] CODE_CPU_TMR = 16'h1005;
endpackage

// File: rtl/irq_lifo.sv
module irq_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] top,
  output logic         nonempty,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mem_q [DEPTH];
  logic          full;
  logic          wr_en;
  logic [IW-1:0] wr_idx, top_idx;

  assign full     = (cnt_q == AW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign top_idx  = IW'(cnt_q - AW'(1));
  assign top      = nonempty ? mem_q[top_idx] : '0;
  assign wr_en    = push && (pop || !full);
  assign wr_idx   = pop ? top_idx : IW'(cnt_q);
  assign ovf      = push && full && !pop;

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop && !full) cnt_d = cnt_q + AW'(1);
    else if (pop && !push)     cnt_d = cnt_q - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= push_data;
  end
endmodule

// File: rtl/irq_pend_cnt.sv
module irq_pend_cnt #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonempty,
  output logic ovf
);
  localparam int AW = $clog2(DEPTH + 1);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          full;

  assign full     = (cnt_q == AW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign ovf      = inc && full && !dec;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec && !full) cnt_d = cnt_q + AW'(1);
    else if (dec && !inc)     cnt_d = cnt_q - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic              fire,
  input  logic              exc_pending,
  input  logic              psw_mck_en,
  input  logic              psw_ext_en,
  input  logic              psw_io_en,
  input  logic              cr_mck_en,
  input  logic              io_cr_en,
  input  logic              mck_ne,
  input  logic [TYPE_W-1:0] mck_type,
  input  logic              ext_ne,
  input  logic [CODE_W-1:0] ext_top,
  input  logic              ckc_pend,
  input  logic              cpt_pend,
  input  logic              io_ne,
  output irq_cls_e          cls,
  output logic [CODE_W-1:0] code,
  output logic              pop_mck,
  output logic              pop_ext,
  output logic              pop_io,
  output logic              clr_ckc,
  output logic              bad_type
);
  logic ext_any;
  assign ext_any = ext_ne || ckc_pend || cpt_pend;

  always_comb begin
    cls      = CLS_NONE;
    code     = '0;
    pop_mck  = 1'b0;
    pop_ext  = 1'b0;
    pop_io   = 1'b0;
    clr_ckc  = 1'b0;
    bad_type = 1'b0;
    if (fire) begin
      if (exc_pending) begin
        cls = CLS_EXC;
      end else if (psw_mck_en && mck_ne) begin
        if (mck_type != TYPE_W'(1)) begin
          bad_type = 1'b1;
        end else if (cr_mck_en) begin
          cls     = CLS_MCK;
          pop_mck = 1'b1;
        end
      end else if (psw_ext_en && ext_any) begin
        cls = CLS_EXT;
        if (ext_ne) begin
          code    = ext_top;
          pop_ext = 1'b1;
        end else if (ckc_pend) begin
          code    = CODE_CLK_CMP;
          clr_ckc = 1'b1;
        end else begin
          code    = CODE_CPU_TMR;
          clr_ckc = 1'b1;
        end
      end else if (psw_io_en && io_ne) begin
        if (io_cr_en) begin
          cls    = CLS_IO;
          pop_io = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_class_arbiter.sv
module irq_class_arbiter
  import irq_arb_pkg::*;
#(
  parameter int EXT_DEPTH = 4,
  parameter int MCK_DEPTH = 4,
  parameter int IO_DEPTH  = 4,
  parameter int TYPE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_push,
  input  logic [15:0]       ext_push_code,
  input  logic              mck_push,
  input  logic [TYPE_W-1:0] mck_push_type,
  input  logic              io_push,
  input  logic              ckc_set,
  input  logic              cpt_set,
  input  logic              psw_mck_en,
  input  logic              psw_ext_en,
  input  logic              psw_io_en,
  input  logic              cr_mck_en,
  input  logic              io_cr_en,
  input  logic              exc_pending,
  input  logic              svc_req,
  output logic              sel_valid,
  output logic [2:0]        sel_class,
  output logic [15:0]       ext_code,
  output logic              hard_irq,
  output logic              fatal
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              svc_q;
  logic              fire;
  logic              ext_ne, mck_ne, io_ne;
  logic [CODE_W-1:0] ext_top;
  logic [TYPE_W-1:0] mck_top;
  logic              ext_ovf, mck_ovf, io_ovf;
  logic              ckc_q, ckc_d, cpt_q, cpt_d;
  logic              fatal_q, fatal_d;
  irq_cls_e          cls_n;
  logic [CODE_W-1:0] code_n;
  logic              pop_mck, pop_ext, pop_io, clr_ckc, bad_type;
  logic              valid_q;
  logic [2:0]        cls_q;
  logic [CODE_W-1:0] code_q;

  assign fire = svc_req && !svc_q;

  irq_lifo #(.W(CODE_W), .DEPTH(EXT_DEPTH)) u_ext_q (
    .clk(clk), .rst_n(rst_int_n), .push(ext_push), .push_data(ext_push_code),
    .pop(pop_ext), .top(ext_top), .nonempty(ext_ne), .ovf(ext_ovf)
  );

  irq_lifo #(.W(TYPE_W), .DEPTH(MCK_DEPTH)) u_mck_q (
    .clk(clk), .rst_n(rst_int_n), .push(mck_push), .push_data(mck_push_type),
    .pop(pop_mck), .top(mck_top), .nonempty(mck_ne), .ovf(mck_ovf)
  );

  irq_pend_cnt #(.DEPTH(IO_DEPTH)) u_io_cnt (
    .clk(clk), .rst_n(rst_int_n), .inc(io_push), .dec(pop_io),
    .nonempty(io_ne), .ovf(io_ovf)
  );

  irq_select #(.TYPE_W(TYPE_W)) u_sel (
    .fire(fire), .exc_pending(exc_pending),
    .psw_mck_en(psw_mck_en), .psw_ext_en(psw_ext_en), .psw_io_en(psw_io_en),
    .cr_mck_en(cr_mck_en), .io_cr_en(io_cr_en),
    .mck_ne(mck_ne), .mck_type(mck_top),
    .ext_ne(ext_ne), .ext_top(ext_top),
    .ckc_pend(ckc_q), .cpt_pend(cpt_q), .io_ne(io_ne),
    .cls(cls_n), .code(code_n),
    .pop_mck(pop_mck), .pop_ext(pop_ext), .pop_io(pop_io),
    .clr_ckc(clr_ckc), .bad_type(bad_type)
  );

  always_comb begin
    ckc_d   = (ckc_q && !clr_ckc) || ckc_set;
    cpt_d   = cpt_q || cpt_set;
    fatal_d = fatal_q || ext_ovf || mck_ovf || io_ovf || bad_type;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      svc_q   <= 1'b0;
      ckc_q   <= 1'b0;
      cpt_q   <= 1'b0;
      fatal_q <= 1'b0;
      valid_q <= 1'b0;
      cls_q   <= '0;
      code_q  <= '0;
    end else begin
      svc_q   <= svc_req;
      ckc_q   <= ckc_d;
      cpt_q   <= cpt_d;
      fatal_q <= fatal_d;
      valid_q <= fire;
      cls_q   <= fire ? cls_n : '0;
      code_q  <= fire ? code_n : '0;
    end
  end

  assign sel_valid = valid_q;
  assign sel_class = cls_q;
  assign ext_code  = code_q;
  assign hard_irq  = ext_ne || mck_ne || io_ne || ckc_q || cpt_q;
  assign fatal     = fatal_q;
endmodule

// File: rtl/irq_class_arbiter_chk.sv
module irq_class_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psw_mck_en,
  input logic        psw_ext_en,
  input logic        psw_io_en,
  input logic        exc_pending,
  input logic        svc_req,
  input logic        sel_valid,
  input logic [2:0]  sel_class,
  input logic [15:0] ext_code,
  input logic        hard_irq,
  input logic        fatal
);
  // R10: single-cycle strobe
  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> !sel_valid);

  // R10: idle outputs are zero
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_class == 3'd0 && ext_code == 16'h0));

  // R1: exception wins
  assert_exc_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(svc_req) && exc_pending && hard_irq) |=> (sel_valid && sel_class == 3'd1));

  // R3: masked classes are not delivered
  assert_mck_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(svc_req) && !psw_mck_en) |=> (sel_class != 3'd2));
  assert_ext_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(svc_req) && !psw_ext_en) |=> (sel_class != 3'd3));
  assert_io_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(svc_req) && !psw_io_en) |=> (sel_class != 3'd4));

  // R8: nothing pending means no asynchronous class
  assert_quiet_no_async_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(svc_req) && !hard_irq) |=> (sel_class == 3'd0 || sel_class == 3'd1));

  // R4: only the external class carries a code
  assert_code_only_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_class != 3'd3) |-> (ext_code == 16'h0));

  // R9: fatal is sticky
  assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);
endmodule

bind irq_class_arbiter irq_class_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .psw_mck_en(psw_mck_en), .psw_ext_en(psw_ext_en), .psw_io_en(psw_io_en),
  .exc_pending(exc_pending), .svc_req(svc_req),
  .sel_valid(sel_valid), .sel_class(sel_class), .ext_code(ext_code),
  .hard_irq(hard_irq), .fatal(fatal)
);

// File: tb/irq_class_arbiter_test.sv
module irq_class_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_push, mck_push, io_push, ckc_set, cpt_set;
  logic [15:0] ext_push_code;
  logic [7:0]  mck_push_type;
  logic        psw_mck_en, psw_ext_en, psw_io_en, cr_mck_en, io_cr_en;
  logic        exc_pending, svc_req;
  logic        sel_valid, hard_irq, fatal;
  logic [2:0]  sel_class;
  logic [15:0] ext_code;

  int errors = 0;
  int checks = 0;

  logic [2:0]  exp_cls[$];
  logic [15:0] exp_code[$];
  string       exp_tag[$];

  always #4 clk = ~clk;

  irq_class_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .ext_push(ext_push), .ext_push_code(ext_push_code),
    .mck_push(mck_push), .mck_push_type(mck_push_type),
    .io_push(io_push), .ckc_set(ckc_set), .cpt_set(cpt_set),
    .psw_mck_en(psw_mck_en), .psw_ext_en(psw_ext_en), .psw_io_en(psw_io_en),
    .cr_mck_en(cr_mck_en), .io_cr_en(io_cr_en),
    .exc_pending(exc_pending), .svc_req(svc_req),
    .sel_valid(sel_valid), .sel_class(sel_class), .ext_code(ext_code),
    .hard_irq(hard_irq), .fatal(fatal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares every selection against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && sel_valid) begin
      if (exp_cls.size() == 0) begin
        check("R10 unexpected strobe", 32'(sel_valid), 32'd0);
      end else begin
        logic [2:0]  c;
        logic [15:0] k;
        string       t;
        c = exp_cls.pop_front();
        k = exp_code.pop_front();
        t = exp_tag.pop_front();
        check({t, " class"}, 32'(sel_class), 32'(c));
        check({t, " code"}, 32'(ext_code), 32'(k));
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    ext_push = 0; mck_push = 0; io_push = 0; ckc_set = 0; cpt_set = 0;
    ext_push_code = '0; mck_push_type = 8'd1;
    psw_mck_en = 1; psw_ext_en = 1; psw_io_en = 1; cr_mck_en = 1; io_cr_en = 1;
    exc_pending = 0; svc_req = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push_ext(input logic [15:0] c);
    ext_push = 1; ext_push_code = c; @(negedge clk); ext_push = 0;
  endtask
  task automatic push_mck(input logic [7:0] t);
    mck_push = 1; mck_push_type = t; @(negedge clk); mck_push = 0;
  endtask
  task automatic push_io();
    io_push = 1; @(negedge clk); io_push = 0;
  endtask
  task automatic pulse_ckc();
    ckc_set = 1; @(negedge clk); ckc_set = 0;
  endtask
  task automatic pulse_cpt();
    cpt_set = 1; @(negedge clk); cpt_set = 0;
  endtask

  // Driver: records the expectation, then raises and drops the request
  task automatic service(input logic [2:0] c, input logic [15:0] k, input string tag);
    exp_cls.push_back(c); exp_code.push_back(k); exp_tag.push_back(tag);
    svc_req = 1; @(negedge clk);
    svc_req = 0; @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // reset state
    check("R8 reset hard_irq", 32'(hard_irq), 0);
    check("R10 reset sel_valid", 32'(sel_valid), 0);
    check("R9 reset fatal", 32'(fatal), 0);
    service(3'd0, 16'h0, "R10 empty request");

    // R1 exception wins, then clock comparator code
    pulse_ckc();
    exc_pending = 1;
    service(3'd1, 16'h0, "R1 exception first");
    exc_pending = 0;
    check("R1 state kept", 32'(hard_irq), 1);
    service(3'd3, 16'h1004, "R4 clock comparator");
    check("R8 drops after ckc", 32'(hard_irq), 0);

    // R5 CPU timer persists
    pulse_ckc(); pulse_cpt();
    service(3'd3, 16'h1004, "R5 ckc before cpt");
    service(3'd3, 16'h1005, "R5 cpt code");
    service(3'd3, 16'h1005, "R5 cpt repeats");
    check("R5 cpt still pending", 32'(hard_irq), 1);
    do_reset();

    // R7 LIFO order, then timer
    push_ext(16'h0040); push_ext(16'h1202); pulse_ckc();
    service(3'd3, 16'h1202, "R7 newest first");
    service(3'd3, 16'h0040, "R7 older next");
    service(3'd3, 16'h1004, "R4 queue before timer");
    check("R8 all consumed", 32'(hard_irq), 0);

    // R2 fixed order
    push_io(); push_ext(16'h0055); push_mck(8'd1);
    service(3'd2, 16'h0, "R2 machine check first");
    service(3'd3, 16'h0055, "R2 external second");
    service(3'd4, 16'h0, "R2 io third");
    check("R8 empty after R2", 32'(hard_irq), 0);

    // R3 masking
    push_mck(8'd1); push_io();
    psw_mck_en = 0;
    service(3'd4, 16'h0, "R3 masked mck skipped");
    psw_mck_en = 1;
    service(3'd2, 16'h0, "R3 mck after unmask");
    pulse_ckc(); push_io();
    psw_ext_en = 0;
    service(3'd4, 16'h0, "R3 masked ext skipped");
    psw_io_en = 0;
    service(3'd0, 16'h0, "R3 everything masked");
    psw_ext_en = 1; psw_io_en = 1;
    service(3'd3, 16'h1004, "R3 ext after unmask");

    // R6 control bit blocks machine check and lower classes
    push_ext(16'h0077); push_mck(8'd1);
    cr_mck_en = 0;
    service(3'd0, 16'h0, "R6 mck blocked");
    check("R6 still pending", 32'(hard_irq), 1);
    cr_mck_en = 1;
    service(3'd2, 16'h0, "R6 mck released");
    service(3'd3, 16'h0077, "R6 ext kept");

    // R11 io control bit
    push_io();
    io_cr_en = 0;
    service(3'd0, 16'h0, "R11 io blocked");
    io_cr_en = 1;
    service(3'd4, 16'h0, "R11 io released");
    check("R8 empty after R11", 32'(hard_irq), 0);

    // R10 held request gives one strobe
    pulse_ckc();
    exp_cls.push_back(3'd3); exp_code.push_back(16'h1004); exp_tag.push_back("R10 held");
    svc_req = 1;
    repeat (4) @(negedge clk);
    svc_req = 0;
    @(negedge clk);
    check("R10 held no more strobes", 32'(exp_cls.size()), 0);

    // R6 bad type is fatal
    check("R9 fatal clear before", 32'(fatal), 0);
    push_mck(8'd2);
    service(3'd0, 16'h0, "R6 bad type");
    check("R6 bad type fatal", 32'(fatal), 1);
    do_reset();

    // R9 overflow
    for (int i = 0; i < 4; i++) push_ext(16'(16'h0100 + i));
    check("R9 full not fatal", 32'(fatal), 0);
    push_ext(16'h0999);
    check("R9 overflow fatal", 32'(fatal), 1);
    service(3'd3, 16'h0103, "R9 dropped entry not stored");
    @(negedge clk);
    check("R9 fatal sticky", 32'(fatal), 1);

    check("scoreboard drained", 32'(exp_cls.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule